// File: doc/BRIEF.md
# Memory-Reference Instruction Executor

This block carries out the memory-reference instructions of a single-accumulator machine with 16-bit words. It owns the 12-bit program counter, the 12-bit address register and the 16-bit data register. It drives a single-port synchronous memory of 4096 words, and that memory is always addressed by the address register. The accumulator itself lives in a neighbouring unit. This block sends it an operand and one of three operate strobes, and it reads the accumulator value back when it needs to store it.

Step timing comes from an external 4-bit sequence counter. That counter resets to zero, advances once per clock and returns to zero on the clock after this block raises its clear request. The block fetches the word, decodes it and resolves an indirect pointer. It then runs the step sequence for the opcode and requests the counter clear on the last step of every instruction. The memory returns read data one clock after the read strobe.

Instruction word layout: bit 15 is the indirect flag, bits 14..12 are the opcode, and bits 11..0 are the address field.

Top module: `mref_exec`

## Requirements
- R1: While rst_n is low, pc_q, opnd and mem_addr are 0 and no read, write, operate strobe or clear request is driven.
- R2: At step 0 the address register takes the program counter. At step 1 the block reads memory at that address and the counter increments. At step 2 the word read becomes the instruction and its bits 11..0 load the address register.
- R3: With bit 15 set and an opcode from 0 to 6, the word at the address field is read at step 3, and its bits 11..0 become the effective address at step 4. With bit 15 clear, the address field itself is the effective address.
- R4: Opcodes 0 (AND), 1 (ADD) and 2 (LDA) read the operand at step 5 and latch it into the data register at step 6. At step 7 they pulse ac_and, ac_add or ac_load with opnd holding the operand, together with sc_clr. The instruction takes 8 cycles.
- R5: Opcode 3 (STA) writes ac_in to the effective address at step 5 with sc_clr. The instruction takes 6 cycles.
- R6: Opcode 4 (BUN) loads the program counter with the effective address at step 5 with sc_clr and writes no memory. The instruction takes 6 cycles.
- R7: Opcode 5 (BSA) writes the zero-extended return address (the incremented program counter) to the effective address at step 5. At step 6 it sets the program counter to the effective address plus one, modulo 4096, with sc_clr. The instruction takes 7 cycles.
- R8: Opcode 6 (ISZ) reads the word, increments it modulo 2^16 and writes it back at step 8 with sc_clr. When the new value is zero it skips one further word. The instruction takes 9 cycles.
- R9: A word with opcode 7 touches no memory after its fetch, changes nothing except the program counter increment, and requests the clear at step 3 (4 cycles).
- R10: A read and a write never occur in the same cycle, and at most one of mem_we, ac_and, ac_add and ac_load is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| t_step | input | 4 | Current step from the external sequence counter |
| sc_clr | output | 1 | Request to zero the sequence counter on the next edge |
| mem_addr | output | 12 | Memory address (the address register) |
| mem_rd | output | 1 | Memory read strobe; data valid next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| ac_in | input | 16 | Current accumulator value |
| ac_and | output | 1 | Accumulator AND with opnd |
| ac_add | output | 1 | Accumulator add opnd |
| ac_load | output | 1 | Accumulator load opnd |
| opnd | output | 16 | Operand for the accumulator (data register) |
| pc_q | output | 12 | Program counter |

## Verification
The assertions assume that t_step behaves like the external counter described above: it holds zero in reset, steps by one each clock and returns to zero exactly one clock after sc_clr. They also assume that memory data returns one cycle after a read. The bench models both of these in its own counter and memory, so every cycle stays within that contract. Program contents are random words from a fixed seed, placed behind a directed prologue. The random words reach every opcode, indirect pointers that land anywhere, arbitrary self-modification and address wrap. A golden instruction-level model checks the result of each instruction.

// File: rtl/mref_exec.sv
module mref_exec #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] t_step,
  output logic          sc_clr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] ac_in,
  output logic          ac_and,
  output logic          ac_add,
  output logic          ac_load,
  output logic [DW-1:0] opnd,
  output logic [AW-1:0] pc_q
);
  localparam int OPW = 3;
  localparam int OPL = DW - 1 - OPW;

  logic [AW-1:0] pc, ar;
  logic [DW-1:0] dr, ir;

  logic t0, t1, t2, t3, t4, t5, t6, t7, t8;
  assign t0 = t_step == SW'(0);
  assign t1 = t_step == SW'(1);
  assign t2 = t_step == SW'(2);
  assign t3 = t_step == SW'(3);
  assign t4 = t_step == SW'(4);
  assign t5 = t_step == SW'(5);
  assign t6 = t_step == SW'(6);
  assign t7 = t_step == SW'(7);
  assign t8 = t_step == SW'(8);

  logic [OPW-1:0] op;
  logic ind, mref, o_and, o_add, o_lda, o_sta, o_bun, o_bsa, o_isz, o_rdop;
  assign op     = ir[DW-2:OPL];
  assign ind    = ir[DW-1];
  assign mref   = op != OPW'(7);
  assign o_and  = op == OPW'(0);
  assign o_add  = op == OPW'(1);
  assign o_lda  = op == OPW'(2);
  assign o_sta  = op == OPW'(3);
  assign o_bun  = op == OPW'(4);
  assign o_bsa  = op == OPW'(5);
  assign o_isz  = op == OPW'(6);
  assign o_rdop = o_and | o_add | o_lda;

  assign mem_addr  = ar;
  assign mem_rd    = rst_n & (t1 | (t3 & ind & mref) | (t5 & (o_rdop | o_isz)));
  assign mem_we    = rst_n & ((t5 & (o_sta | o_bsa)) | (t8 & o_isz));
  assign mem_wdata = o_sta ? ac_in : o_bsa ? {{(DW-AW){1'b0}}, pc} : dr;
  assign ac_and    = rst_n & t7 & o_and;
  assign ac_add    = rst_n & t7 & o_add;
  assign ac_load   = rst_n & t7 & o_lda;
  assign sc_clr    = rst_n & ((t3 & ~mref) | (t7 & o_rdop) | (t5 & (o_sta | o_bun))
                            | (t6 & o_bsa) | (t8 & o_isz));
  assign opnd      = dr;
  assign pc_q      = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ar <= '0;
      dr <= '0;
      ir <= '0;
    end else begin
      if (t0) ar <= pc;
      if (t1) pc <= pc + AW'(1);
      if (t2) begin
        ir <= mem_rdata;
        ar <= mem_rdata[AW-1:0];
      end
      if (t4 & ind & mref) ar <= mem_rdata[AW-1:0];
      if (t5 & o_bun) pc <= ar;
      if (t5 & o_bsa) ar <= ar + AW'(1);
      if (t6 & o_bsa) pc <= ar;
      if (t6 & (o_rdop | o_isz)) dr <= mem_rdata;
      if (t7 & o_isz) dr <= dr + DW'(1);
      if (t8 & o_isz & (dr == '0)) pc <= pc + AW'(1);
    end
  end
endmodule

// File: rtl/mref_exec_chk.sv
module mref_exec_chk #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] t_step,
  input logic          sc_clr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] ac_in,
  input logic          ac_and,
  input logic          ac_add,
  input logic          ac_load,
  input logic [DW-1:0] opnd,
  input logic [AW-1:0] pc_q
);
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n |-> !(mem_rd | mem_we | sc_clr | ac_and | ac_add | ac_load));

  p_fetch_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    t_step == SW'(1) |-> mem_rd);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    t_step == SW'(1) |=> pc_q == $past(pc_q) + AW'(1));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    t_step == SW'(0) |=> mem_addr == $past(pc_q));

  p_strobe_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_and | ac_add | ac_load) |-> (sc_clr && t_step == SW'(7)));

  p_no_early_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_step < SW'(5) |-> !mem_we);

  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_rd);

  p_one_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, ac_and, ac_add, ac_load}));
endmodule

bind mref_exec mref_exec_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (.*);

// File: tb/sim_mref_exec.sv
module sim_mref_exec;
  localparam int CLK_PERIOD = 10;
  localparam int NINSTR = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] t_step;
  logic sc_clr, mem_rd, mem_we, ac_and, ac_add, ac_load;
  logic [11:0] mem_addr, pc_q;
  logic [15:0] mem_wdata, mem_rdata, ac, opnd;

  logic [15:0] mem  [0:4095];
  logic [15:0] gmem [0:4095];
  logic [11:0] gpc;
  logic [15:0] gac;
  int total = 0, bad = 0, viol = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mref_exec u0 (
    .clk(clk), .rst_n(rst_n), .t_step(t_step), .sc_clr(sc_clr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ac_in(ac), .ac_and(ac_and), .ac_add(ac_add),
    .ac_load(ac_load), .opnd(opnd), .pc_q(pc_q)
  );

  always @(posedge clk) begin
    if (!rst_n || sc_clr) t_step <= 4'd0;
    else t_step <= t_step + 4'd1;
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (!rst_n) ac <= 16'h0;
    else if (ac_and) ac <= ac & opnd;
    else if (ac_add) ac <= ac + opnd;
    else if (ac_load) ac <= opnd;
  end

  always @(negedge clk)
    if (rst_n && ((mem_rd && mem_we) ||
        (int'(mem_we) + int'(ac_and) + int'(ac_add) + int'(ac_load) > 1)))
      viol++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string optag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic gstep(output int cyc, output bit wr, output logic [11:0] wa);
    logic [15:0] w, v;
    logic [11:0] ea;
    logic [2:0] op;
    w = gmem[gpc];
    gpc = gpc + 12'd1;
    op = w[14:12];
    ea = w[11:0];
    wr = 0;
    wa = 12'd0;
    cyc = 4;
    if (op != 3'd7) begin
      if (w[15]) ea = gmem[ea][11:0];
      case (op)
        3'd0: begin gac = gac & gmem[ea]; cyc = 8; end
        3'd1: begin gac = gac + gmem[ea]; cyc = 8; end
        3'd2: begin gac = gmem[ea]; cyc = 8; end
        3'd3: begin gmem[ea] = gac; wr = 1; wa = ea; cyc = 6; end
        3'd4: begin gpc = ea; cyc = 6; end
        3'd5: begin gmem[ea] = {4'h0, gpc}; wr = 1; wa = ea; gpc = ea + 12'd1; cyc = 7; end
        default: begin
          v = gmem[ea] + 16'd1;
          gmem[ea] = v; wr = 1; wa = ea; cyc = 9;
          if (v == 16'h0) gpc = gpc + 12'd1;
        end
      endcase
    end
  endtask

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w;
    gmem[a] = w;
  endtask

  initial begin
    void'($urandom(32'd7091));
    for (int i = 0; i < 4096; i++) put(i, 16'($urandom));
    put(0, 16'h2064);   put(100, 16'h1234);
    put(1, 16'h9065);   put(101, 16'h0066); put(102, 16'hF00F);
    put(2, 16'h0067);   put(103, 16'h0FF0);
    put(3, 16'hB068);   put(104, 16'h0069);
    put(4, 16'h606A);   put(106, 16'hFFFF);
    put(5, 16'h47FF);
    put(6, 16'h606B);   put(107, 16'h0005);
    put(7, 16'h50C8);
    put(201, 16'h7800);
    put(202, 16'hC06C); put(108, 16'h0FFF);
    put(4095, 16'h412C);
    gpc = 12'd0;
    gac = 16'h0;

    repeat (3) @(posedge clk);
    #1;
    chk(pc_q == 12'd0 && opnd == 16'h0 && mem_addr == 12'd0, "R1", "reset regs",
        int'(pc_q), 0);
    chk(!(mem_rd | mem_we | sc_clr | ac_and | ac_add | ac_load), "R1", "reset strobes",
        int'({mem_rd, mem_we, sc_clr, ac_and, ac_add, ac_load}), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NINSTR; k++) begin
      int cyc, n;
      bit wr;
      logic [11:0] wa, fpc;
      logic [15:0] iw;
      fpc = gpc;
      iw = gmem[gpc];
      gstep(cyc, wr, wa);
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (n == 2)
          chk(mem_rd && mem_addr == fpc, "R2", "fetch address", int'(mem_addr), int'(fpc));
      end while (!sc_clr && n < 20);
      @(posedge clk);
      #1;
      chk(n == cyc, optag(iw[14:12]), "cycle count", n, cyc);
      chk(pc_q == gpc, optag(iw[14:12]), "next pc", int'(pc_q), int'(gpc));
      chk(ac == gac, (iw[15] && iw[14:12] != 3'd7) ? "R3" : optag(iw[14:12]),
          "accumulator", int'(ac), int'(gac));
      if (wr)
        chk(mem[wa] == gmem[wa], (iw[15]) ? "R3" : optag(iw[14:12]),
            "written word", int'(mem[wa]), int'(gmem[wa]));
    end

    begin
      int diff = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== gmem[i]) diff++;
      chk(diff == 0, "R9", "memory image", diff, 0);
    end
    chk(viol == 0, "R10", "exclusive strobes", viol, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule